// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block takes a processor from supply-up to its first instruction fetch. At power-up it holds the core in reset long enough for the clock generator to settle. It then fires the master-reset actions: emptying the stack pointers, masking interrupts and clearing the mode/status register. When reset is released it chooses between handing control to a boot loader and starting the core directly. Finally it enables instruction fetch from the start address.

The choice at release depends on a memory-map strap and on whether another master is requesting the bus. With the strap low and the bus free, a one-cycle boot-start pulse is issued and the block waits for the loader's done handshake. With the strap high, fetch starts at once. If the bus is requested, the block parks until the request goes away and then looks at the strap. A reset that arrives after power-up is filtered for a minimum width. Such a reset skips the stabilisation count and releases as soon as the raw reset goes away. All logic is synchronous to `clk`. `powerOn` is the block's own reset.

Top module: `reset_boot_seq`

## Requirements
- R1: From the first clock edge with `powerOn` low, `coreRst` stays 1 for LOCK_CYCLES+1 edges at least. The first LOCK_CYCLES of those edges ignore `rawRstN`. The later edges keep `coreRst` at 1 while `rawRstN` is 0.
- R2: `stackClr`, `irqMask` and `statClr` are 1 together for exactly one cycle at each entry into reset. That cycle starts at edge LOCK_CYCLES after power-up, or at the qualifying edge of a later reset.
- R3: After power-up, `rawRstN` may be sampled 0 for MIN_PULSE consecutive edges in the hold, boot or run phase. Then `coreRst` is 1 after the MIN_PULSE-th edge and `fetchEn` is 0. `coreRst` returns to 0 at the first edge that samples `rawRstN` high, with no stabilisation count.
- R4: A `rawRstN` low pulse shorter than MIN_PULSE edges after power-up is ignored. `coreRst` and the strobes stay 0, and `fetchEn` stays as it was.
- R5: At release, with `mapStrap`=0 and `busReq`=0, `bootStart` is 1 for exactly the cycle after the release edge. `fetchEn` remains 0 until the boot-done handshake.
- R6: While booting, an edge that samples `bootDone`=1 makes `fetchEn` 1, with `fetchAddr` equal to START_ADDR (0).
- R7: At release, with `mapStrap`=1 and `busReq`=0, `fetchEn` is 1 right after the release edge and `bootStart` never pulses.
- R8: At release, with `busReq`=1, `coreRst`, `fetchEn` and `bootStart` all stay 0 while the request stays high. The strap is evaluated at the edge that samples `busReq`=0.
- R9: `powerOn`=1 at any time forces `coreRst`=1 and `fetchEn`=0 after the next edge and restarts the stabilisation count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| powerOn | input | 1 | Power-on flag, active high; block reset |
| rawRstN | input | 1 | Raw external reset, active low, pre-synchronised |
| mapStrap | input | 1 | Memory-map strap: 0 = boot, 1 = direct start |
| busReq | input | 1 | External bus request pending |
| bootDone | input | 1 | Boot loader finished |
| coreRst | output | 1 | Internal core reset, active high |
| stackClr | output | 1 | One-cycle strobe: empty all stack pointers |
| irqMask | output | 1 | One-cycle strobe: mask all interrupts |
| statClr | output | 1 | One-cycle strobe: clear mode/status register |
| bootStart | output | 1 | One-cycle strobe: begin boot loading |
| fetchEn | output | 1 | Core may fetch instructions |
| fetchAddr | output | ADDR_W | First fetch address, valid with fetchEn |

## Verification
A wrong state shows at the ports within one edge. A phase entered too early or too late shifts the falling edge of `coreRst` or the single strobe cycle. Entering boot when the direct start was due, or the reverse, swaps `bootStart` and `fetchEn` on the cycle after release. A reset-width counter that is off by one either raises `coreRst` one edge early or late, or lets a short glitch through. The sweep of pulse widths around MIN_PULSE sees either fault on the edge where it happens.

// File: rtl/reset_boot_pkg.sv
package reset_boot_pkg;

  typedef enum logic [2:0] {
    ST_POR_WAIT  = 3'd0,
    ST_RESET     = 3'd1,
    ST_BUS_HOLD  = 3'd2,
    ST_BOOT      = 3'd3,
    ST_RUN       = 3'd4
  } seqState_t;

  // strobes from control to datapath, all for the coming edge
  typedef struct packed {
    logic porCntEn;    // advance stabilisation counter
    logic pulseArm;    // qualify later resets by width
    logic enterReset;  // next state is reset, current is not
    logic enterBoot;   // next state is boot, current is not
    logic runNext;     // next state is run
    logic rstNext;     // next state holds core in reset
  } seqCtl_t;

endpackage

// File: rtl/reset_boot_ctrl.sv
module reset_boot_ctrl
  import reset_boot_pkg::*;
(
  input  logic    clk,
  input  logic    powerOn,
  input  logic    rawRstN,
  input  logic    mapStrap,
  input  logic    busReq,
  input  logic    bootDone,
  input  logic    porDone,
  input  logic    pulseHit,
  output seqCtl_t ctl
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (powerOn) state <= ST_POR_WAIT;
    else         state <= nextState;
  end

  // release decision shared by reset and bus-hold exits
  seqState_t releaseTarget;
  always_comb releaseTarget = mapStrap ? ST_RUN : ST_BOOT;

  always_comb begin
    nextState    = state;
    ctl.porCntEn = 1'b0;
    ctl.pulseArm = 1'b0;
    unique case (state)
      ST_POR_WAIT: begin
        ctl.porCntEn = 1'b1;
        if (porDone) nextState = ST_RESET;
      end
      ST_RESET: begin
        if (rawRstN) nextState = busReq ? ST_BUS_HOLD : releaseTarget;
      end
      ST_BUS_HOLD: begin
        ctl.pulseArm = 1'b1;
        if (pulseHit)     nextState = ST_RESET;
        else if (!busReq) nextState = releaseTarget;
      end
      ST_BOOT: begin
        ctl.pulseArm = 1'b1;
        if (pulseHit)      nextState = ST_RESET;
        else if (bootDone) nextState = ST_RUN;
      end
      ST_RUN: begin
        ctl.pulseArm = 1'b1;
        if (pulseHit) nextState = ST_RESET;
      end
      default: nextState = ST_POR_WAIT;
    endcase
  end

  always_comb begin
    ctl.enterReset = (nextState == ST_RESET) && (state != ST_RESET);
    ctl.enterBoot  = (nextState == ST_BOOT)  && (state != ST_BOOT);
    ctl.runNext    = (nextState == ST_RUN);
    ctl.rstNext    = (nextState == ST_POR_WAIT) || (nextState == ST_RESET);
  end

  // R1: leaving the stabilisation wait only once the counter says so
  a_r1_por_exit: assert property (@(posedge clk) disable iff (powerOn)
    (state == ST_RESET && $past(state) == ST_POR_WAIT) |-> $past(porDone));

  // R5: boot phase entered only with the strap low and the bus free
  a_r5_boot_entry: assert property (@(posedge clk) disable iff (powerOn)
    (state == ST_BOOT && $past(state) != ST_BOOT) |-> $past(!mapStrap && !busReq));

  // R8: bus hold is left only by a dropped request or a reset
  a_r8_hold_exit: assert property (@(posedge clk) disable iff (powerOn)
    (state == ST_BUS_HOLD) |=>
      (state == ST_BUS_HOLD || state == ST_RESET || !$past(busReq)));

endmodule

// File: rtl/reset_boot_dp.sv
module reset_boot_dp
  import reset_boot_pkg::*;
#(
  parameter int LOCK_CYCLES = 2000,
  parameter int MIN_PULSE   = 8,
  parameter int ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              powerOn,
  input  logic              rawRstN,
  input  seqCtl_t           ctl,
  output logic              porDone,
  output logic              pulseHit,
  output logic              coreRst,
  output logic              stackClr,
  output logic              irqMask,
  output logic              statClr,
  output logic              bootStart,
  output logic              fetchEn,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int POR_W = $clog2(LOCK_CYCLES + 1);
  localparam int PW_W  = $clog2(MIN_PULSE + 1);
  localparam logic [POR_W-1:0] POR_LAST = POR_W'(LOCK_CYCLES - 1);
  localparam logic [PW_W-1:0]  PW_LAST  = PW_W'(MIN_PULSE - 1);

  logic [POR_W-1:0] porCnt;
  logic [PW_W-1:0]  pulseCnt;

  // stabilisation counter, runs only during the power-up wait
  always_ff @(posedge clk) begin
    if (powerOn)           porCnt <= '0;
    else if (ctl.porCntEn) porCnt <= porCnt + 1'b1;
  end
  assign porDone = (porCnt == POR_LAST);

  // width qualifier for resets after power-up
  always_ff @(posedge clk) begin
    if (powerOn || !ctl.pulseArm || rawRstN) pulseCnt <= '0;
    else if (!pulseHit)                      pulseCnt <= pulseCnt + 1'b1;
  end
  assign pulseHit = ctl.pulseArm && !rawRstN && (pulseCnt == PW_LAST);

  // registered outputs
  always_ff @(posedge clk) begin
    if (powerOn) begin
      coreRst   <= 1'b1;
      stackClr  <= 1'b0;
      irqMask   <= 1'b0;
      statClr   <= 1'b0;
      bootStart <= 1'b0;
      fetchEn   <= 1'b0;
      fetchAddr <= '0;
    end else begin
      coreRst   <= ctl.rstNext;
      stackClr  <= ctl.enterReset;
      irqMask   <= ctl.enterReset;
      statClr   <= ctl.enterReset;
      bootStart <= ctl.enterBoot;
      fetchEn   <= ctl.runNext;
      fetchAddr <= ctl.runNext ? START_ADDR : '0;
    end
  end

  // R2: master-reset strobes last a single cycle
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (powerOn)
    stackClr |=> !stackClr);

  // R3: a reset after power-up needs the raw reset low
  a_r3_reset_cause: assert property (@(posedge clk) disable iff (powerOn)
    ($rose(coreRst) && !$past(powerOn)) |-> $past(!rawRstN));

  // R7: fetch never overlaps the core reset
  a_r7_fetch_no_reset: assert property (@(posedge clk) disable iff (powerOn)
    fetchEn |-> !coreRst);

  // R5: boot start is a single-cycle pulse
  a_r5_boot_single: assert property (@(posedge clk) disable iff (powerOn)
    bootStart |=> !bootStart);

endmodule

// File: rtl/reset_boot_seq.sv
module reset_boot_seq
  import reset_boot_pkg::*;
#(
  parameter int LOCK_CYCLES = 2000,
  parameter int MIN_PULSE   = 8,
  parameter int ADDR_W      = 14,
  parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
  input  logic              clk,
  input  logic              powerOn,
  input  logic              rawRstN,
  input  logic              mapStrap,
  input  logic              busReq,
  input  logic              bootDone,
  output logic              coreRst,
  output logic              stackClr,
  output logic              irqMask,
  output logic              statClr,
  output logic              bootStart,
  output logic              fetchEn,
  output logic [ADDR_W-1:0] fetchAddr
);

  seqCtl_t ctl;
  logic    porDone;
  logic    pulseHit;

  reset_boot_ctrl i_ctrl (
    .clk      (clk),
    .powerOn  (powerOn),
    .rawRstN  (rawRstN),
    .mapStrap (mapStrap),
    .busReq   (busReq),
    .bootDone (bootDone),
    .porDone  (porDone),
    .pulseHit (pulseHit),
    .ctl      (ctl)
  );

  reset_boot_dp #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .MIN_PULSE   (MIN_PULSE),
    .ADDR_W      (ADDR_W),
    .START_ADDR  (START_ADDR)
  ) i_dp (
    .clk       (clk),
    .powerOn   (powerOn),
    .rawRstN   (rawRstN),
    .ctl       (ctl),
    .porDone   (porDone),
    .pulseHit  (pulseHit),
    .coreRst   (coreRst),
    .stackClr  (stackClr),
    .irqMask   (irqMask),
    .statClr   (statClr),
    .bootStart (bootStart),
    .fetchEn   (fetchEn),
    .fetchAddr (fetchAddr)
  );

endmodule

// File: tb/test_reset_boot_seq.sv
module test_reset_boot_seq;

  localparam int LOCK = 20;
  localparam int MINP = 4;
  localparam int AW   = 14;

  logic clk = 1'b0;
  logic powerOn = 1'b1, rawRstN = 1'b1, mapStrap = 1'b0, busReq = 1'b0, bootDone = 1'b0;
  logic coreRst, stackClr, irqMask, statClr, bootStart, fetchEn;
  logic [AW-1:0] fetchAddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  reset_boot_seq #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP), .ADDR_W(AW)) i_reset_boot_seq (
    .clk(clk), .powerOn(powerOn), .rawRstN(rawRstN), .mapStrap(mapStrap),
    .busReq(busReq), .bootDone(bootDone), .coreRst(coreRst), .stackClr(stackClr),
    .irqMask(irqMask), .statClr(statClr), .bootStart(bootStart),
    .fetchEn(fetchEn), .fetchAddr(fetchAddr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int strobes();
    return {29'd0, stackClr, irqMask, statClr};
  endfunction

  // from boot phase: handshake into run (R6)
  task automatic finishBoot();
    step(3);
    chk("R5 no fetch before done", fetchEn, 0);
    bootDone = 1'b1;
    step(1);
    chk("R6 fetchEn after done", fetchEn, 1);
    chk("R6 fetchAddr", fetchAddr, 0);
    bootDone = 1'b0;
  endtask

  // first edge after a release, bus free
  task automatic checkRelease(input bit strap, input string tag);
    chk({tag, " coreRst released"}, coreRst, 0);
    if (strap) begin
      chk("R7 direct fetch", fetchEn, 1);
      chk("R7 no bootStart", bootStart, 0);
    end else begin
      chk("R5 bootStart pulse", bootStart, 1);
      chk("R5 fetchEn low", fetchEn, 0);
      step(1);
      chk("R5 bootStart single", bootStart, 0);
      finishBoot();
    end
  endtask

  task automatic powerUp(input bit strap, input bit bus, input bit holdRaw);
    powerOn = 1'b1; mapStrap = strap; busReq = bus; rawRstN = !holdRaw;
    step(2);
    chk("R9 coreRst in power-on", coreRst, 1);
    chk("R9 fetchEn in power-on", fetchEn, 0);
    chk("R9 strobes in power-on", strobes(), 0);
    powerOn = 1'b0;
    step(LOCK - 1);
    chk("R1 still in stabilisation", coreRst, 1);
    chk("R2 no strobe yet", strobes(), 0);
    step(1);
    chk("R1 reset at count end", coreRst, 1);
    chk("R2 strobes at entry", strobes(), 7);
    if (holdRaw) begin
      step(3);
      chk("R1 held by raw reset", coreRst, 1);
      chk("R2 strobes single", strobes(), 0);
      rawRstN = 1'b1;
    end
    step(1);
    if (bus) begin
      chk("R8 coreRst low in hold", coreRst, 0);
      for (int i = 0; i < 3; i++) begin
        chk("R8 no fetch in hold", fetchEn, 0);
        chk("R8 no boot in hold", bootStart, 0);
        step(1);
      end
      busReq = 1'b0;
      step(1);
    end
    checkRelease(strap, "R1");
  endtask

  // later reset of width w from run phase
  task automatic pulseRun(input bit strap, input int w);
    rawRstN = 1'b0;
    for (int i = 1; i <= w; i++) begin
      step(1);
      if (w < MINP) begin
        chk("R4 short pulse coreRst", coreRst, 0);
        chk("R4 short pulse fetchEn", fetchEn, 1);
        chk("R4 short pulse strobes", strobes(), 0);
      end else begin
        chk("R3 coreRst by width", coreRst, (i >= MINP) ? 1 : 0);
        chk("R3 fetchEn by width", fetchEn, (i >= MINP) ? 0 : 1);
        chk("R2 strobes later reset", strobes(), (i == MINP) ? 7 : 0);
      end
    end
    rawRstN = 1'b1;
    step(1);
    if (w < MINP) begin
      chk("R4 still running", fetchEn, 1);
      chk("R4 no reset", coreRst, 0);
    end else begin
      checkRelease(strap, "R3");
    end
  endtask

  initial begin
    step(1);
    chk("R9 reset state coreRst", coreRst, 1);
    chk("R9 reset state outputs", {bootStart, fetchEn, stackClr}, 0);
    for (int s = 0; s < 2; s++)
      for (int b = 0; b < 2; b++)
        for (int h = 0; h < 2; h++) begin
          powerUp(s[0], b[0], h[0]);
          for (int w = 1; w <= MINP + 1; w++) pulseRun(s[0], w);
        end
    // later reset during boot phase, then bus hold on release
    powerUp(1'b0, 1'b0, 1'b0);
    rawRstN = 1'b0;
    powerOn = 1'b1; step(1); powerOn = 1'b0; rawRstN = 1'b1;
    step(LOCK + 1);
    chk("R5 boot after power-up", bootStart, 1);
    rawRstN = 1'b0;
    step(MINP);
    chk("R3 reset from boot", coreRst, 1);
    busReq = 1'b1; mapStrap = 1'b1; rawRstN = 1'b1;
    step(1);
    chk("R8 hold after boot reset", {coreRst, fetchEn, bootStart}, 0);
    busReq = 1'b0;
    step(1);
    chk("R8 strap read at drop", fetchEn, 1);
    chk("R8 no boot with strap 1", bootStart, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule